// File: doc/BRIEF.md
# Byte-Fed CRC-32 Checksum Peripheral

This block computes a 32-bit cyclic redundancy checksum over a byte stream that software pushes through a small register window. Writing a source code to the control register starts a session: the checksum register is reloaded with its seed, the zero flag is dropped and, for any active source, the busy flag rises. Each byte written to the data register while busy is folded into the checksum in a single clock, and the new value is visible on the next cycle.

Three kinds of session exist. A software session (I/O) ends when software writes a one to bit 0 of the status register. A session tied to one of up to four DMA channels ends on that channel's done or abort strobe. A flash-scan session ends on a flash-done strobe. The DMA and flash logic are outside this block; only their completion strobes come in. When a session ends, the zero flag records whether the checksum register is zero at that moment. This is how a packet carrying its own checksum is verified.

The engine uses the reflected polynomial 0xEDB88320 and a seed of 0xFFFFFFFF, and folds each byte least-significant bit first. The raw register drives one output port and its bitwise complement drives a second. The complement is the conventional CRC-32 value that goes onto a packet.

Top module: `crc_periph`

## Requirements
- R1: After reset the control register reads 0, the status register reads 0x00, and `checksum` reads 0xFFFFFFFF.
- R2: A write to address 0 stores `wr_data[3:0]` as the source code, reloads `checksum` with 0xFFFFFFFF and sets BUSY (status bit 0) on the next cycle for the active codes: 0001 (I/O), 0010 (flash) and 01cc (DMA channel cc). Codes 0000, 0011 and every code with bit 3 set leave BUSY at 0.
- R3: A write to address 2 while BUSY is 1 folds the byte into the checksum, LSB first, with polynomial 0xEDB88320. The result appears on `checksum` one cycle later. Bytes "123456789" after a reload give `checksum_inv` = 0xCBF43926.
- R4: A write to address 2 while BUSY is 0 leaves `checksum` unchanged.
- R5: With source 0001, a write to address 1 with bit 0 set clears BUSY on the next cycle. A status write with bit 0 clear, or any status write under another source, leaves BUSY unchanged.
- R6: With source 01cc, a pulse on `dma_done[cc]` or `dma_abort[cc]` clears BUSY. Strobes on other channels and `flash_done` are ignored.
- R7: With source 0010, `flash_done` clears BUSY. DMA strobes are ignored.
- R8: ZERO (status bit 1) is set when BUSY clears and the checksum register, including any byte folded in that same cycle, is zero. Any control write clears ZERO.
- R9: Status bits 7:2 read 0. The data register at address 2 and address 3 read 0. Address 0 reads the source code in bits 3:0.
- R10: After a message, appending the raw `checksum` bytes least-significant byte first drives `checksum` to 0. Appending the `checksum_inv` bytes instead leaves `checksum_inv` = 0x2144DF1C.
- R11: A control write in the same cycle as a completion strobe takes priority: BUSY follows the new code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data, 3 unused |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read of the addressed register |
| dma_done | input | N_DMA | Per-channel DMA completion strobe |
| dma_abort | input | N_DMA | Per-channel DMA abort strobe |
| flash_done | input | 1 | Flash-scan completion strobe |
| checksum | output | 32 | Raw checksum register |
| checksum_inv | output | 32 | Bitwise complement of the checksum register |

## Verification
A corrupted checksum register shows on `checksum` in the cycle right after the faulty fold. Because every later byte carries the error forward, the fault also surfaces at the residue check as a missing ZERO. A wrong source or busy state surfaces through the status read one cycle after the offending write or strobe: BUSY either stays up past its completion strobe or falls on a strobe meant for another channel. The bench compares status, both checksum outputs and the read port against a behavioural model on every clock, so a divergence is caught in the cycle it appears.

// File: rtl/crc_pkg.sv
package crc_pkg;

  localparam int          CRC_W    = 32;
  localparam int          BYTE_W   = 8;
  localparam int          SRC_W    = 4;
  localparam int          ADDR_W   = 2;
  localparam logic [31:0] CRC_POLY = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED = 32'hFFFF_FFFF;

  typedef enum logic [1:0] {
    SK_OFF   = 2'd0,
    SK_IO    = 2'd1,
    SK_FLASH = 2'd2,
    SK_DMA   = 2'd3
  } src_kind_e;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL   = 2'd0,
    RA_STATUS = 2'd1,
    RA_DATA   = 2'd2,
    RA_SPARE  = 2'd3
  } reg_addr_e;

  // Map a source code to the kind of session it starts.
  function automatic src_kind_e kind_of(logic [SRC_W-1:0] code, int n_dma);
    src_kind_e k;
    k = SK_OFF;
    if (code[3]) begin
      k = SK_OFF;
    end else if (code[2]) begin
      if (int'(code[1:0]) < n_dma) k = SK_DMA;
    end else if (code[1:0] == 2'b01) begin
      k = SK_IO;
    end else if (code[1:0] == 2'b10) begin
      k = SK_FLASH;
    end
    return k;
  endfunction

endpackage

// File: rtl/crc_rst_sync.sv
module crc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/crc_byte_fold.sv
module crc_byte_fold #(
  parameter int          W    = 32,
  parameter int          DW   = 8,
  parameter logic [W-1:0] POLY = 32'hEDB88320
) (
  input  logic [W-1:0]  crc_i,
  input  logic [DW-1:0] byte_i,
  output logic [W-1:0]  crc_o
);

  logic [W-1:0] stage [0:DW];

  assign stage[0] = crc_i ^ {{(W-DW){1'b0}}, byte_i};

  for (genvar g = 0; g < DW; g++) begin : g_bit
    assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY) : (stage[g] >> 1);
  end

  assign crc_o = stage[DW];

endmodule

// File: rtl/crc_core.sv
module crc_core #(
  parameter int          W    = 32,
  parameter int          DW   = 8,
  parameter logic [W-1:0] POLY = 32'hEDB88320,
  parameter logic [W-1:0] SEED = 32'hFFFF_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          fold_i,
  input  logic [DW-1:0] byte_i,
  output logic [W-1:0]  crc_q_o,
  output logic [W-1:0]  crc_d_o
);

  logic [W-1:0] crc_q, crc_d, folded;
  logic         crc_en;

  crc_byte_fold #(.W(W), .DW(DW), .POLY(POLY)) u_fold (
    .crc_i  (crc_q),
    .byte_i (byte_i),
    .crc_o  (folded)
  );

  always_comb begin
    crc_d  = crc_q;
    crc_en = load_i | fold_i;
    if (load_i)      crc_d = SEED;
    else if (fold_i) crc_d = folded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= SEED;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_q_o = crc_q;
  assign crc_d_o = crc_d;

endmodule

// File: rtl/crc_src_ctrl.sv
module crc_src_ctrl
  import crc_pkg::*;
#(
  parameter int N_DMA = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_we_i,
  input  logic [SRC_W-1:0] sel_code_i,
  input  logic             sw_clr_i,
  input  logic [N_DMA-1:0] dma_done_i,
  input  logic [N_DMA-1:0] dma_abort_i,
  input  logic             flash_done_i,
  input  logic             crc_next_zero_i,
  output logic [SRC_W-1:0] src_o,
  output logic             busy_o,
  output logic             zero_o
);

  logic [SRC_W-1:0] src_q, src_d;
  logic             busy_q, busy_d;
  logic             zero_q, zero_d;
  logic             state_en;
  src_kind_e        kind_q;
  logic [N_DMA-1:0] ch_hit;
  logic             dma_fin, finish;

  assign kind_q = kind_of(src_q, N_DMA);

  for (genvar g = 0; g < N_DMA; g++) begin : g_ch
    assign ch_hit[g] = (src_q[1:0] == 2'(g)) & (dma_done_i[g] | dma_abort_i[g]);
  end

  assign dma_fin = |ch_hit;

  always_comb begin
    unique case (kind_q)
      SK_IO:    finish = sw_clr_i;
      SK_FLASH: finish = flash_done_i;
      SK_DMA:   finish = dma_fin;
      default:  finish = 1'b0;
    endcase
  end

  always_comb begin
    src_d    = src_q;
    busy_d   = busy_q;
    zero_d   = zero_q;
    state_en = 1'b0;
    if (sel_we_i) begin
      src_d    = sel_code_i;
      busy_d   = (kind_of(sel_code_i, N_DMA) != SK_OFF);
      zero_d   = 1'b0;
      state_en = 1'b1;
    end else if (busy_q && finish) begin
      busy_d   = 1'b0;
      zero_d   = crc_next_zero_i;
      state_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      busy_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (state_en) begin
      src_q  <= src_d;
      busy_q <= busy_d;
      zero_q <= zero_d;
    end
  end

  assign src_o  = src_q;
  assign busy_o = busy_q;
  assign zero_o = zero_q;

endmodule

// File: rtl/crc_periph.sv
module crc_periph
  import crc_pkg::*;
#(
  parameter int          N_DMA = 4,
  parameter logic [31:0] POLY  = CRC_POLY,
  parameter logic [31:0] SEED  = CRC_SEED
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] rd_data,
  input  logic [N_DMA-1:0]  dma_done,
  input  logic [N_DMA-1:0]  dma_abort,
  input  logic              flash_done,
  output logic [CRC_W-1:0]  checksum,
  output logic [CRC_W-1:0]  checksum_inv
);

  logic             rst_n_sync;
  logic             sel_we, sw_clr, dat_we, fold_en;
  logic [SRC_W-1:0] src_w;
  logic             busy_w, zero_w;
  logic [CRC_W-1:0] crc_q, crc_d;

  crc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  assign sel_we  = wr_en && (addr == RA_CTRL);
  assign sw_clr  = wr_en && (addr == RA_STATUS) && wr_data[0];
  assign dat_we  = wr_en && (addr == RA_DATA);
  assign fold_en = dat_we && busy_w;

  crc_core #(.W(CRC_W), .DW(BYTE_W), .POLY(POLY), .SEED(SEED)) u_core (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .load_i  (sel_we),
    .fold_i  (fold_en),
    .byte_i  (wr_data),
    .crc_q_o (crc_q),
    .crc_d_o (crc_d)
  );

  crc_src_ctrl #(.N_DMA(N_DMA)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n_sync),
    .sel_we_i        (sel_we),
    .sel_code_i      (wr_data[SRC_W-1:0]),
    .sw_clr_i        (sw_clr),
    .dma_done_i      (dma_done),
    .dma_abort_i     (dma_abort),
    .flash_done_i    (flash_done),
    .crc_next_zero_i (crc_d == '0),
    .src_o           (src_w),
    .busy_o          (busy_w),
    .zero_o          (zero_w)
  );

  always_comb begin
    rd_data = '0;
    unique case (addr)
      RA_CTRL:   rd_data[SRC_W-1:0] = src_w;
      RA_STATUS: rd_data[1:0]       = {zero_w, busy_w};
      default:   rd_data            = '0;
    endcase
  end

  assign checksum     = crc_q;
  assign checksum_inv = ~crc_q;

endmodule

// File: rtl/crc_periph_chk.sv
module crc_periph_chk #(
  parameter int N_DMA = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       addr,
  input logic             wr_en,
  input logic [7:0]       wr_data,
  input logic [7:0]       rd_data,
  input logic [N_DMA-1:0] dma_done,
  input logic [N_DMA-1:0] dma_abort,
  input logic             flash_done,
  input logic [3:0]       src,
  input logic             busy,
  input logic             zero,
  input logic [31:0]      checksum
);

  logic ctrl_wr, live_code, dma_src, dma_hit;

  assign ctrl_wr   = wr_en && (addr == 2'd0);
  assign live_code = (wr_data[3:0] == 4'd1) || (wr_data[3:0] == 4'd2) ||
                     ((wr_data[3:2] == 2'b01) && (int'(wr_data[1:0]) < N_DMA));
  assign dma_src   = (src[3:2] == 2'b01) && (int'(src[1:0]) < N_DMA);
  assign dma_hit   = dma_src && (dma_done[src[1:0]] || dma_abort[src[1:0]]);

  assert_live_sel_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && live_code) |=> busy);

  assert_dead_sel_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && !live_code) |=> !busy);

  assert_idle_data_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd2 && !busy) |=> $stable(checksum));

  assert_dma_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && dma_src && !dma_hit && !ctrl_wr) |=> busy);

  assert_flash_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && src == 4'd2 && flash_done && !ctrl_wr) |=> !busy);

  assert_sel_clears_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !zero);

  assert_status_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 2'd1) |-> (rd_data[7:2] == 6'd0));

endmodule

bind crc_periph crc_periph_chk #(.N_DMA(N_DMA)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .dma_done   (dma_done),
  .dma_abort  (dma_abort),
  .flash_done (flash_done),
  .src        (src_w),
  .busy       (busy_w),
  .zero       (zero_w),
  .checksum   (checksum)
);

// File: tb/sim_crc_periph.sv
module sim_crc_periph;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [1:0]     addr = 2'd1;
  logic           wr_en = 1'b0;
  logic [7:0]     wr_data = 8'd0;
  logic [7:0]     rd_data;
  logic [NCH-1:0] dma_done = '0;
  logic [NCH-1:0] dma_abort = '0;
  logic           flash_done = 1'b0;
  logic [31:0]    checksum, checksum_inv;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;
  bit  compare_on = 1'b0;

  always #4 clk = ~clk;

  crc_periph #(.N_DMA(NCH)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .dma_done(dma_done), .dma_abort(dma_abort),
    .flash_done(flash_done), .checksum(checksum), .checksum_inv(checksum_inv)
  );

  // Behavioural reference model
  logic [3:0]  m_src;
  logic        m_busy, m_zero;
  logic [31:0] m_crc;

  function automatic logic [31:0] ref_fold(logic [31:0] c, logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ d[i];
      r  = r >> 1;
      if (fb) r = r ^ 32'hEDB88320;
    end
    return r;
  endfunction

  function automatic bit ref_active(logic [3:0] c);
    return (c == 4'd1) || (c == 4'd2) || ((c[3:2] == 2'b01) && (int'(c[1:0]) < NCH));
  endfunction

  function automatic logic [7:0] ref_rd(logic [1:0] a);
    if (a == 2'd0) return {4'd0, m_src};
    if (a == 2'd1) return {6'd0, m_zero, m_busy};
    return 8'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin : model
    logic [31:0] nxt;
    bit fin;
    if (!rst_n) begin
      m_src = 4'd0; m_busy = 1'b0; m_zero = 1'b0; m_crc = 32'hFFFF_FFFF;
    end else if (wr_en && addr == 2'd0) begin
      m_src = wr_data[3:0]; m_crc = 32'hFFFF_FFFF;
      m_busy = ref_active(wr_data[3:0]); m_zero = 1'b0;
    end else begin
      nxt = m_crc;
      if (wr_en && addr == 2'd2 && m_busy) nxt = ref_fold(m_crc, wr_data);
      fin = 1'b0;
      if (m_busy) begin
        if (m_src == 4'd1)      fin = wr_en && addr == 2'd1 && wr_data[0];
        else if (m_src == 4'd2) fin = flash_done;
        else                    fin = dma_done[m_src[1:0]] | dma_abort[m_src[1:0]];
      end
      if (fin) begin m_busy = 1'b0; m_zero = (nxt == 32'd0); end
      m_crc = nxt;
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      chk("R3 checksum vs model", checksum, m_crc);
      chk("R10 complement vs model", checksum_inv, ~m_crc);
      chk("R9 read port vs model", {24'd0, rd_data}, {24'd0, ref_rd(addr)});
    end
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); #1;
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); #1;
    wr_en = 1'b0; addr = 2'd1; wr_data = 8'd0;
    #1;
  endtask

  task automatic strobe(logic [NCH-1:0] dd, logic [NCH-1:0] da, logic fd);
    @(negedge clk); #1;
    dma_done = dd; dma_abort = da; flash_done = fd;
    @(negedge clk); #1;
    dma_done = '0; dma_abort = '0; flash_done = 1'b0;
    #1;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    @(negedge clk); #1;
    addr = a; #1;
    v = rd_data;
    @(negedge clk); #1;
    addr = 2'd1; #1;
  endtask

  task automatic feed_msg();
    string msg;
    msg = "123456789";
    for (int i = 0; i < msg.len(); i++) wr(2'd2, msg[i]);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0]  v;
    logic [31:0] snap;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    compare_on = 1'b1;
    #1;

    // R1 reset state
    chk("R1 status", {24'd0, rd_data}, 32'h00);
    chk("R1 checksum", checksum, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R1 control", {24'd0, v}, 32'h0);

    // R4 data while idle
    wr(2'd2, 8'h5A);
    chk("R4 idle byte ignored", checksum, 32'hFFFF_FFFF);

    // R2 / R3 I/O session with check string
    wr(2'd0, 8'h01);
    chk("R2 busy after I/O select", {24'd0, rd_data}, 32'h01);
    feed_msg();
    chk("R3 check value", checksum_inv, 32'hCBF43926);
    chk("R3 raw value", checksum, 32'h340BC6D9);

    // R5 status write with bit0 clear, then clear
    wr(2'd1, 8'hFE);
    chk("R5 bit0 clear ignored", {24'd0, rd_data}, 32'h01);
    wr(2'd1, 8'h01);
    chk("R5 sw clear", {24'd0, rd_data}, 32'h00);
    chk("R8 no zero on nonzero crc", {31'd0, rd_data[1]}, 32'd0);

    // R10 append raw register -> zero residue, R8 zero flag
    wr(2'd0, 8'h01);
    feed_msg();
    snap = checksum;
    for (int i = 0; i < 4; i++) wr(2'd2, snap[8*i +: 8]);
    chk("R10 raw residue", checksum, 32'h0);
    wr(2'd1, 8'h01);
    chk("R8 zero set at end", {24'd0, rd_data}, 32'h02);
    wr(2'd0, 8'h01);
    chk("R8 zero cleared by select", {24'd0, rd_data}, 32'h01);
    chk("R2 seed reload", checksum, 32'hFFFF_FFFF);

    // R10 append complement -> magic residue
    feed_msg();
    snap = checksum_inv;
    for (int i = 0; i < 4; i++) wr(2'd2, snap[8*i +: 8]);
    chk("R10 complement residue", checksum_inv, 32'h2144DF1C);
    wr(2'd1, 8'h01);

    // R6 DMA channel 2
    wr(2'd0, 8'h06);
    chk("R6 busy on dma2", {24'd0, rd_data}, 32'h01);
    wr(2'd2, 8'hA7);
    strobe(4'b0010, 4'b1001, 1'b1);
    chk("R6 other channels ignored", {24'd0, rd_data}, 32'h01);
    strobe(4'b0000, 4'b0100, 1'b0);
    chk("R6 abort clears", {24'd0, rd_data}, 32'h00);

    // R6 DMA channel 3 done, R5 sw clear ignored
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h01);
    chk("R5 sw clear ignored under dma", {24'd0, rd_data}, 32'h01);
    strobe(4'b1000, 4'b0000, 1'b0);
    chk("R6 done clears", {24'd0, rd_data}, 32'h00);

    // R7 flash
    wr(2'd0, 8'h02);
    strobe(4'b1111, 4'b1111, 1'b0);
    chk("R7 dma ignored under flash", {24'd0, rd_data}, 32'h01);
    strobe(4'b0000, 4'b0000, 1'b1);
    chk("R7 flash done clears", {24'd0, rd_data}, 32'h00);

    // R2 reserved / disabled codes, R4 no fold
    wr(2'd0, 8'h08);
    chk("R2 reserved code idle", {24'd0, rd_data}, 32'h00);
    wr(2'd2, 8'h33);
    chk("R4 reserved no fold", checksum, 32'hFFFF_FFFF);
    wr(2'd0, 8'h03);
    chk("R2 code 3 idle", {24'd0, rd_data}, 32'h00);
    wr(2'd0, 8'h00);
    chk("R2 code 0 idle", {24'd0, rd_data}, 32'h00);

    // R11 select wins over completion in same cycle
    wr(2'd0, 8'h02);
    @(negedge clk); #1;
    addr = 2'd0; wr_data = 8'h02; wr_en = 1'b1; flash_done = 1'b1;
    @(negedge clk); #1;
    wr_en = 1'b0; flash_done = 1'b0; addr = 2'd1; wr_data = 8'd0;
    #1;
    chk("R11 select wins", {24'd0, rd_data}, 32'h01);

    // R9 read map
    rd(2'd0, v); chk("R9 control readback", {24'd0, v}, 32'h02);
    rd(2'd2, v); chk("R9 data reads zero", {24'd0, v}, 32'h0);
    rd(2'd3, v); chk("R9 spare reads zero", {24'd0, v}, 32'h0);

    repeat (2) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

endmodule